// File: doc/BRIEF.md
# Interleaved Line-Read Controller

This block fetches one four-word line from a main memory that is built either as a single bank or as two interleaved banks. A requester offers a line number with a valid/ready handshake. The controller then spends one cycle sending the address and waits out the bank access latency. After that it returns the words in ascending order over a one-word path, with a strobe for each word and a completion pulse on the last one.

In two-bank mode, even-numbered words sit in bank 0 and odd-numbered words in bank 1. One access fetches a pair of words, but the two words still leave one after the other, each taking a full transfer slot. The next pair's access starts only after both words of the current pair have been sent. A line therefore costs 1 + 4·12 + 4·2 = 57 cycles with one bank and 1 + 2·12 + 4·2 = 33 cycles with two. The storage is modelled inside the block as register arrays loaded at reset. A cycle counter is brought out so that the timing can be observed.

Top module: `line_read_ctrl`

## Requirements
- R1: After reset, and whenever no read is in progress, `req_ready` is 1 while `rd_valid`, `rd_done` and `cycle_count` are 0. With `req_valid` low the block stays in this state.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1, and the line number is captured on that edge. While a read is in progress `req_ready` is 0, and any request or line change on the inputs has no effect on the data returned.
- R3: With one bank, `rd_done` is high in the 57th cycle after the accepting edge.
- R4: With two banks, `rd_done` is high in the 33rd cycle after the accepting edge.
- R5: Each read returns exactly four words in the order 0, 1, 2, 3. `rd_word` gives the index of the word on the bus.
- R6: Word w of line L reads 0xA5 in bits 31:24, L in bits 23:16, w in bits 15:8, and the low byte of (L xor 16·w) in bits 7:0.
- R7: `rd_valid` is a one-cycle pulse. Word k appears in cycle 1 + (k/B + 1)·12 + (k + 1)·2 after acceptance, where B is the bank count and k/B is integer division. The first word therefore comes in cycle 15 in both modes.
- R8: With two banks, the two words of a pair are 2 cycles apart and consecutive pairs are 14 cycles apart. With one bank, every word is 14 cycles after the one before it.
- R9: `rd_done` is high only in the cycle that carries word 3 with `rd_valid` high.
- R10: `req_ready` is 1 in the cycle after `rd_done`. A request held high through the end of a read is accepted on the next edge.
- R11: During the n-th cycle after acceptance, `cycle_count` reads n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request offered |
| req_line | input | LINE_AW | Line number to read |
| req_ready | output | 1 | Controller idle, request can be taken |
| rd_valid | output | 1 | Returned word present this cycle |
| rd_word | output | $clog2(WPL) | Index of the returned word within the line |
| rd_data | output | DATA_W | Returned word, zero when not valid |
| rd_done | output | 1 | Last word of the line is on the bus |
| cycle_count | output | CNT_W | Cycles since acceptance, 0 when idle |

## Verification
The bench counts every cycle from the accepting edge. It checks the exact cycle of each word, so a design that overlapped the second word of a pair with the first would deliver it early. A design that started the next access before the pair was drained would finish before cycle 33. A design that gave each word its own access would finish at 57 in two-bank mode.

Requests are driven with a different line while a read is in flight. A controller that re-captured the address would then return data from the wrong line. A request held across the done pulse checks that the controller is ready again on the next cycle, not one cycle late. Data is compared word by word against the fill pattern, which catches bank swaps and wrong-word ordering.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_XFER   = 2'd3
    } lrc_state_e;

    // Fill value of word w in line l (32 bits, sized by the caller)
    function automatic logic [31:0] lrc_fill(input int unsigned l, input int unsigned w);
        logic [7:0] lb;
        logic [7:0] wb;
        lb = 8'(l);
        wb = 8'(w);
        return {8'hA5, lb, wb, lb ^ 8'(w << 4)};
    endfunction

endpackage

// File: rtl/lrc_bank.sv
module lrc_bank #(
    parameter int BANK_ID   = 0,
    parameter int NUM_BANKS = 2,
    parameter int WPL       = 4,
    parameter int LINE_AW   = 4,
    parameter int DATA_W    = 32,
    localparam int LINES    = 1 << LINE_AW,
    localparam int GROUPS   = WPL / NUM_BANKS,
    localparam int DEPTH    = LINES * GROUPS,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    import lrc_pkg::*;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    // Array holds its contents; no write path exists.
    always_comb begin
        for (int e = 0; e < DEPTH; e++) mem_d[e] = mem_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++)
                mem_q[e] <= DATA_W'(lrc_fill(e / GROUPS, (e % GROUPS) * NUM_BANKS + BANK_ID));
        end else begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= mem_d[e];
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/lrc_sequencer.sv
module lrc_sequencer #(
    parameter int NUM_BANKS  = 2,
    parameter int WPL        = 4,
    parameter int LINE_AW    = 4,
    parameter int ADDR_CYC   = 1,
    parameter int ACCESS_LAT = 12,
    parameter int XFER_LAT   = 2,
    parameter int CNT_W      = 8,
    localparam int WIDX_W    = $clog2(WPL),
    localparam int TOTAL     = ADDR_CYC + (WPL / NUM_BANKS) * ACCESS_LAT + WPL * XFER_LAT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LINE_AW-1:0] req_line,
    output logic               req_ready,
    output logic               fetch_en,
    output logic [LINE_AW-1:0] cur_line,
    output logic [WIDX_W-1:0]  cur_word,
    output logic               word_valid,
    output logic               line_done,
    output logic [CNT_W-1:0]   cycle_count
);
    import lrc_pkg::*;

    typedef struct packed {
        lrc_state_e         st;
        logic [CNT_W-1:0]   ph;
        logic [WIDX_W-1:0]  word;
        logic [LINE_AW-1:0] line;
        logic [CNT_W-1:0]   cyc;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d          = q;
        fetch_en   = 1'b0;
        word_valid = 1'b0;
        line_done  = 1'b0;
        if (q.st != ST_IDLE) d.cyc = q.cyc + 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_ADDR;
                    d.ph   = '0;
                    d.word = '0;
                    d.line = req_line;
                    d.cyc  = CNT_W'(1);
                end
            end
            ST_ADDR: begin
                if (q.ph == CNT_W'(ADDR_CYC - 1)) begin
                    d.st = ST_ACCESS;
                    d.ph = '0;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            ST_ACCESS: begin
                if (q.ph == CNT_W'(ACCESS_LAT - 1)) begin
                    fetch_en = 1'b1;
                    d.st     = ST_XFER;
                    d.ph     = '0;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            ST_XFER: begin
                if (q.ph == CNT_W'(XFER_LAT - 1)) begin
                    word_valid = 1'b1;
                    d.ph       = '0;
                    if (q.word == WIDX_W'(WPL - 1)) begin
                        line_done = 1'b1;
                        d.st      = ST_IDLE;
                        d.cyc     = '0;
                    end else begin
                        d.word = q.word + 1'b1;
                        if ((int'(q.word) % NUM_BANKS) == NUM_BANKS - 1) d.st = ST_ACCESS;
                    end
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.ph   <= '0;
            q.word <= '0;
            q.line <= '0;
            q.cyc  <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign cur_line    = q.line;
    assign cur_word    = q.word;
    assign cycle_count = q.cyc;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!word_valid && !line_done && cycle_count == '0));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && cycle_count == CNT_W'(1)));

    p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !line_done) |=> $stable(cur_line));

    p_done_cycle_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> cycle_count == CNT_W'(TOTAL));

    p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (word_valid && cur_word == WIDX_W'(WPL - 1)));

    p_ready_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> req_ready);

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !line_done) |=> (cycle_count == $past(cycle_count) + 1'b1));

    generate
        if (XFER_LAT > 1) begin : g_pulse
            p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
                word_valid |=> !word_valid);
        end
    endgenerate

endmodule

// File: rtl/lrc_fetch_buf.sv
module lrc_fetch_buf #(
    parameter int NUM_BANKS = 2,
    parameter int WPL       = 4,
    parameter int DATA_W    = 32,
    localparam int WIDX_W   = $clog2(WPL)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fetch_en,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_data,
    input  logic [WIDX_W-1:0]           cur_word,
    input  logic                        word_valid,
    output logic [DATA_W-1:0]           out_data
);
    logic [DATA_W-1:0] buf_q [NUM_BANKS];
    logic [DATA_W-1:0] buf_d [NUM_BANKS];

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            buf_d[b] = fetch_en ? bank_data[b*DATA_W +: DATA_W] : buf_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) buf_q[b] <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) buf_q[b] <= buf_d[b];
        end
    end

    assign out_data = word_valid ? buf_q[int'(cur_word) % NUM_BANKS] : '0;

    p_no_fetch_on_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> !word_valid);

endmodule

// File: rtl/line_read_ctrl.sv
module line_read_ctrl #(
    parameter int NUM_BANKS  = 2,
    parameter int WPL        = 4,
    parameter int LINE_AW    = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_CYC   = 1,
    parameter int ACCESS_LAT = 12,
    parameter int XFER_LAT   = 2,
    parameter int CNT_W      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [LINE_AW-1:0]       req_line,
    output logic                     req_ready,
    output logic                     rd_valid,
    output logic [$clog2(WPL)-1:0]   rd_word,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_done,
    output logic [CNT_W-1:0]         cycle_count
);
    localparam int WIDX_W = $clog2(WPL);
    localparam int GROUPS = WPL / NUM_BANKS;
    localparam int DEPTH  = (1 << LINE_AW) * GROUPS;
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                        fetch_en;
    logic [LINE_AW-1:0]          cur_line;
    logic [WIDX_W-1:0]           cur_word;
    logic                        word_valid;
    logic                        line_done;
    logic [IDX_W-1:0]            bank_idx;
    logic [NUM_BANKS*DATA_W-1:0] bank_data;

    lrc_sequencer #(
        .NUM_BANKS(NUM_BANKS), .WPL(WPL), .LINE_AW(LINE_AW), .ADDR_CYC(ADDR_CYC),
        .ACCESS_LAT(ACCESS_LAT), .XFER_LAT(XFER_LAT), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_ready(req_ready), .fetch_en(fetch_en), .cur_line(cur_line),
        .cur_word(cur_word), .word_valid(word_valid), .line_done(line_done),
        .cycle_count(cycle_count)
    );

    // The group of the pair being fetched: all banks read the same entry.
    assign bank_idx = IDX_W'(int'(cur_line) * GROUPS + int'(cur_word) / NUM_BANKS);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            lrc_bank #(
                .BANK_ID(b), .NUM_BANKS(NUM_BANKS), .WPL(WPL),
                .LINE_AW(LINE_AW), .DATA_W(DATA_W)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .rd_idx(bank_idx),
                .rd_data(bank_data[b*DATA_W +: DATA_W])
            );
        end
    endgenerate

    lrc_fetch_buf #(
        .NUM_BANKS(NUM_BANKS), .WPL(WPL), .DATA_W(DATA_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .bank_data(bank_data),
        .cur_word(cur_word), .word_valid(word_valid), .out_data(rd_data)
    );

    assign rd_valid = word_valid;
    assign rd_word  = cur_word;
    assign rd_done  = line_done;

endmodule

// File: tb/line_read_ctrl_bench.sv
module line_read_ctrl_bench;
    localparam int ACC = 12;
    localparam int XF  = 2;
    localparam int WPL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_v = 1'b0;
    logic [3:0] req_line = '0;
    logic sel = 1'b1;
    int tests = 0;
    int fails = 0;
    int ticks = 0;

    always #2 clk = ~clk;

    logic v1, v2, rdy1, rdy2, val1, val2, dn1, dn2;
    logic [1:0] w1, w2;
    logic [31:0] d1, d2;
    logic [7:0] c1, c2;
    assign v2 = req_v & sel;
    assign v1 = req_v & ~sel;

    line_read_ctrl #(.NUM_BANKS(2)) u_line_read_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(v2), .req_line(req_line), .req_ready(rdy2),
        .rd_valid(val2), .rd_word(w2), .rd_data(d2), .rd_done(dn2), .cycle_count(c2));

    line_read_ctrl #(.NUM_BANKS(1)) u_line_read_ctrl_1b (
        .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_line(req_line), .req_ready(rdy1),
        .rd_valid(val1), .rd_word(w1), .rd_data(d1), .rd_done(dn1), .cycle_count(c1));

    wire        s_rdy = sel ? rdy2 : rdy1;
    wire        s_val = sel ? val2 : val1;
    wire        s_dn  = sel ? dn2  : dn1;
    wire [1:0]  s_w   = sel ? w2   : w1;
    wire [31:0] s_d   = sel ? d2   : d1;
    wire [7:0]  s_c   = sel ? c2   : c1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fill(input int l, input int w);
        logic [7:0] lb = 8'(l);
        return {8'hA5, lb, 8'(w), lb ^ 8'(16 * w)};
    endfunction

    function automatic int slot(input int banks, input int k);
        return 1 + (k / banks + 1) * ACC + (k + 1) * XF;
    endfunction

    task automatic run_read(input int banks, input int line, input int exp_total,
                            input bit hold, input bit poke);
        int n = 0;
        int got = 0;
        int bad_pos = 0;
        int bad_dat = 0;
        int bad_ord = 0;
        string rq = (banks == 1) ? "R3" : "R4";
        sel = (banks == 2);
        while (!s_rdy) @(negedge clk);
        req_line = 4'(line);
        req_v = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            n++;
            if (n == 1 && !hold) req_v = 1'b0;
            if (poke && n == 5) begin req_v = 1'b1; req_line = 4'(line ^ 5); end
            if (poke && n == 20) chk(!s_rdy, "R2", "ready while busy", s_rdy, 0);
            if (poke && n == 30) begin req_v = 1'b0; req_line = 4'(line); end
            if (n == 7) chk(s_c == 8'(7), "R11", "cycle_count mid-read", s_c, 7);
            if (s_val) begin
                if (s_w != 2'(got)) bad_ord++;
                if (n != slot(banks, got)) begin
                    bad_pos++;
                    $display("FAIL R7 word %0d cycle: actual %0d expected %0d", got, n, slot(banks, got));
                end
                if (s_d != fill(line, got)) begin
                    bad_dat++;
                    $display("FAIL R6 line %0d word %0d: actual 0x%0h expected 0x%0h",
                             line, got, s_d, fill(line, got));
                end
                got++;
            end
            if (s_dn || n > 200) break;
        end
        chk(n == exp_total, rq, "done cycle", n, exp_total);
        chk(s_c == 8'(exp_total), "R11", "cycle_count at done", s_c, exp_total);
        chk(s_val && s_w == 2'd3, "R9", "done with last word", {s_val, s_w}, 3'b111);
        chk(got == WPL && bad_ord == 0, "R5", "word count/order", got, WPL);
        tests++;
        if (bad_pos != 0) fails++;
        tests++;
        if (bad_dat != 0) fails++;
        if (banks == 2) chk(slot(2, 1) - slot(2, 0) == 2 && slot(2, 2) - slot(2, 1) == 14 &&
                            bad_pos == 0, "R8", "pair spacing", bad_pos, 0);
        else chk(bad_pos == 0, "R8", "single spacing", bad_pos, 0);
    endtask

    // banks, line, expected done cycle
    localparam int VEC [0:7][0:2] = '{
        '{1, 0, 57}, '{2, 0, 33}, '{1, 5, 57}, '{2, 9, 33},
        '{2, 15, 33}, '{1, 15, 57}, '{2, 6, 33}, '{1, 10, 57}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk(rdy1 && rdy2 && !val1 && !val2 && !dn1 && !dn2, "R1", "in reset", {rdy1, rdy2}, 2'b11);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(rdy1 && rdy2 && c1 == 0 && c2 == 0 && !val1 && !val2, "R1", "idle after reset",
            {c1, c2}, 0);
        for (int i = 0; i < 8; i++) run_read(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0, 1'b0);
        // requests during a read are ignored
        run_read(2, 3, 33, 1'b0, 1'b1);
        run_read(1, 12, 57, 1'b0, 1'b1);
        // back-to-back: request held across done
        run_read(2, 7, 33, 1'b1, 1'b0);
        @(negedge clk);
        chk(rdy2 == 1'b1, "R10", "ready after done", rdy2, 1);
        run_read(2, 8, 33, 1'b0, 1'b0);
        // idle with no request stays quiet
        req_v = 1'b0;
        repeat (5) @(negedge clk);
        chk(rdy1 && rdy2 && !val1 && !val2 && c1 == 0 && c2 == 0, "R1", "idle no request",
            {val1, val2}, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        ticks++;
        if (ticks > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000", ticks);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule